// File: doc/BRIEF.md
# Three-byte instruction fetch sequencer

This block is the hardwired control path of a small 8-bit processor in which every operation takes the form A ← A op B. Each instruction sits in memory as a fixed block of three bytes. The first byte holds the opcode, the second holds the register selectors and the third holds an immediate value or a memory address. The block keeps its own program counter, a memory address register, a memory buffer register, an instruction register, an input buffer and an output buffer. A step counter walks through fetch and execute micro-steps. In each step the block drives a 16-bit control word to the datapath, the memory address and a write strobe.

A separate datapath reads the control word. It holds the register file, the ALU and the shifter, and it returns its ALU result. Register 0 in the selector fields stands for the external data input rather than a stored register. The block drives that input from its input buffer. A move between registers is issued as an addition with the A bus forced to zero, because the ALU can only pass a value through from its A port. The block uses the same trick to route a register to memory.

Top module: `tribyte_ctrl`

## Requirements
- R1: While reset is held, the block drives `mem_we`=0, `cw`=0, `a_bus_dis`=0 and `mem_addr`=0. After reset is released, the first instruction block is fetched from address 0.
- R2: Counting from step 0 of an instruction at block address P, `mem_addr` shows P in cycle 1, P+1 in cycle 3 and P+2 in cycle 5. The next block starts at P+3.
- R3: Only bits 5..0 of the opcode byte select the operation. Bits 7..6 are ignored.
- R4: In the register byte, bits 6..4 select the A/destination register and bits 2..0 select the B register. Bits 7 and 3 are ignored.
- R5: The control word has this layout: bits 15..13 A select, 12..10 B select, 9..7 destination (000 = no load), 6..4 ALU function, 3 carry-in, 2..0 shifter (000 = pass). Outside its execute step it is zero. The instruction lengths are: register ALU ops, moves and no-ops 7 cycles; input load and memory store 8 cycles; memory load 10 cycles.
- R6: Opcodes 04 (inc), 06 (dec), 08 (add), 0E (sub), 16 (and), 19 (or) and 1C (xor) put {A, B, A, fn, 000} on the control word in cycle 6. The fn/carry nibble is 0001, 0110, 0010, 0101, 1100, 1000 and 1010 respectively.
- R7: Opcode 01 drives A select 000 with `a_bus_dis`=1, B select from the B field, destination from the A field and ALU nibble 0010, all in cycle 6.
- R8: Opcode 00 captures `in_port` in cycle 6. It then presents the captured value on `dp_in` in cycle 7, with control word {000, 000, A, 0000, 000}.
- R9: Opcode 02 reads memory at the operand address in cycle 7. It presents that byte on `dp_in` in cycle 9, with control word {000, 000, A, 0000, 000}.
- R10: Opcode 03 drives {000, B, 000, 0010, 000} with `a_bus_dis`=1 in cycle 6. It asserts `mem_we` for exactly cycle 7, with `mem_addr` = the operand byte and `mem_wdata` = the datapath result captured in cycle 6.
- R11: Opcodes 14, 15 and every other opcode not listed above do nothing: the control word stays zero and no write occurs for 7 cycles.
- R12: The program counter is 8 bits wide and wraps. A block at FF reads FF, 00 and 01, and the next block starts at 02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address (memory address register) |
| mem_rdata | input | 8 | Byte read from memory at `mem_addr` |
| mem_wdata | output | 8 | Write data (output buffer) |
| mem_we | output | 1 | 1 = write `mem_wdata` to `mem_addr` at this clock edge |
| cw | output | 16 | Datapath control word |
| a_bus_dis | output | 1 | Forces the ALU A operand to zero |
| dp_in | output | 8 | Data offered to the datapath when a selector is 000 |
| dp_result | input | 8 | Datapath ALU result |
| in_port | input | 8 | External input port |

## Verification
The hardest case to reach is the wrap of the program counter from FF back to 00. Only a long run of instructions gets there, and after the wrap the block fetches misaligned bytes that form arbitrary instructions, possibly including memory writes. To reach it, the bench fills all unused memory with a no-op opcode so that fetching runs on into the wrap. Its reference model decodes whatever bytes it finds, including after the wrap. A store to a location followed later by a load from that same location shows that a write lands where a later read finds it.

// File: rtl/tribyte_ctrl.sv
module tribyte_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  output logic [15:0]  cw,
  output logic         a_bus_dis,
  output logic [W-1:0] dp_in,
  input  logic [W-1:0] dp_result,
  input  logic [W-1:0] in_port
);

  typedef enum logic [2:0] {K_NOP, K_ALU, K_MOV, K_IN, K_LD, K_ST} kind_t;

  logic [W-1:0] pc, mar, mbr, inp, outb;
  logic [5:0]   ir;
  logic [2:0]   ra, rb;
  logic [3:0]   step, last;
  logic [3:0]   fc;
  kind_t        kind;

  always_comb begin
    kind = K_NOP;
    fc   = 4'b0000;
    case (ir)
      6'h00: kind = K_IN;
      6'h01: kind = K_MOV;
      6'h02: kind = K_LD;
      6'h03: kind = K_ST;
      6'h04: begin kind = K_ALU; fc = 4'b0001; end
      6'h06: begin kind = K_ALU; fc = 4'b0110; end
      6'h08: begin kind = K_ALU; fc = 4'b0010; end
      6'h0E: begin kind = K_ALU; fc = 4'b0101; end
      6'h16: begin kind = K_ALU; fc = 4'b1100; end
      6'h19: begin kind = K_ALU; fc = 4'b1000; end
      6'h1C: begin kind = K_ALU; fc = 4'b1010; end
      default: kind = K_NOP;
    endcase
  end

  always_comb begin
    case (kind)
      K_IN, K_ST: last = 4'd7;
      K_LD:       last = 4'd9;
      default:    last = 4'd6;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      pc   <= '0;
      mar  <= '0;
      mbr  <= '0;
      inp  <= '0;
      outb <= '0;
      ir   <= '0;
      ra   <= '0;
      rb   <= '0;
    end else begin
      step <= (step == last) ? 4'd0 : step + 4'd1;
      case (step)
        4'd0: mar <= pc;
        4'd1, 4'd3, 4'd5: begin
          mbr <= mem_rdata;
          pc  <= pc + 1'b1;
        end
        4'd2: begin
          ir  <= mbr[5:0];
          mar <= pc;
        end
        4'd4: begin
          ra  <= mbr[6:4];
          rb  <= mbr[2:0];
          mar <= pc;
        end
        4'd6: begin
          if (kind == K_IN) inp <= in_port;
          if (kind == K_LD || kind == K_ST) mar <= mbr;
          if (kind == K_ST) outb <= dp_result;
        end
        4'd7: if (kind == K_LD) mbr <= mem_rdata;
        4'd8: if (kind == K_LD) inp <= mbr;
        default: ;
      endcase
    end
  end

  always_comb begin
    cw        = '0;
    a_bus_dis = 1'b0;
    mem_we    = 1'b0;
    if (step == 4'd6) begin
      case (kind)
        K_ALU: cw = {ra, rb, ra, fc, 3'b000};
        K_MOV: begin
          cw        = {3'b000, rb, ra, 4'b0010, 3'b000};
          a_bus_dis = 1'b1;
        end
        K_ST: begin
          cw        = {3'b000, rb, 3'b000, 4'b0010, 3'b000};
          a_bus_dis = 1'b1;
        end
        default: ;
      endcase
    end
    if ((step == 4'd7 && kind == K_IN) || (step == 4'd9 && kind == K_LD))
      cw = {3'b000, 3'b000, ra, 4'b0000, 3'b000};
    if (step == 4'd7 && kind == K_ST)
      mem_we = 1'b1;
  end

  assign mem_addr  = mar;
  assign mem_wdata = outb;
  assign dp_in     = inp;

endmodule

// File: rtl/tribyte_ctrl_chk.sv
module tribyte_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic [15:0] cw,
  input logic        a_bus_dis
);

  p_rst_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (cw == 16'h0 && !mem_we && !a_bus_dis));

  p_cw_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cw != 16'h0) |=> (cw == 16'h0));

  p_mov_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
    a_bus_dis |-> (cw[6:3] == 4'b0010 && cw[15:13] == 3'b000 && cw[2:0] == 3'b000));

  p_we_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_we_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cw == 16'h0 && !a_bus_dis));

  p_we_after_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(a_bus_dis) && $past(cw[9:7]) == 3'b000));

endmodule

bind tribyte_ctrl tribyte_ctrl_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .mem_we(mem_we),
  .cw(cw),
  .a_bus_dis(a_bus_dis)
);

// File: tb/tribyte_ctrl_bench.sv
module tribyte_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr, mem_rdata, mem_wdata, dp_in, dp_result, in_port;
  logic        mem_we, a_bus_dis;
  logic [15:0] cw;

  logic [7:0] mem  [256];
  logic [7:0] regs [8];

  int tests = 0;
  int fails = 0;
  int ninstr = 0;
  logic [7:0] pc_m = 8'h00;

  typedef struct packed {
    logic [15:0] cw;
    logic        adis;
    logic        we;
    logic        ca;
    logic [7:0]  addr;
    logic        cd;
    logic [7:0]  din;
    logic        cwd;
    logic [7:0]  wd;
  } exp_t;

  exp_t  q[$];
  string qt[$];

  always #10 clk = ~clk;

  tribyte_ctrl u_tribyte_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we),
    .cw(cw), .a_bus_dis(a_bus_dis),
    .dp_in(dp_in), .dp_result(dp_result), .in_port(in_port)
  );

  assign mem_rdata = mem[mem_addr];

  // behavioural datapath: register file + ALU driven by the control word
  logic [7:0] av, bv;
  always_comb begin
    av = a_bus_dis ? 8'h00 : (cw[15:13] == 3'd0 ? dp_in : regs[cw[15:13]]);
    bv = (cw[12:10] == 3'd0) ? dp_in : regs[cw[12:10]];
    case (cw[6:3])
      4'b0000: dp_result = av;
      4'b0001: dp_result = av + 8'd1;
      4'b0010: dp_result = av + bv;
      4'b0011: dp_result = av + bv + 8'd1;
      4'b0100: dp_result = av - bv - 8'd1;
      4'b0101: dp_result = av - bv;
      4'b0110: dp_result = av - 8'd1;
      4'b1000, 4'b1001: dp_result = av | bv;
      4'b1010, 4'b1011: dp_result = av ^ bv;
      4'b1100, 4'b1101: dp_result = av & bv;
      4'b1110, 4'b1111: dp_result = ~av;
      default: dp_result = av;
    endcase
  end

  always @(posedge clk) begin
    if (rst_n && cw[9:7] != 3'd0) regs[cw[9:7]] <= dp_result;
    if (rst_n && mem_we) mem[mem_addr] <= mem_wdata;
  end

  task automatic ck(input string t, input string w, input int a, input int x);
    tests++;
    if (a != x) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", t, w, a, x);
    end
  endtask

  function automatic exp_t idle();
    exp_t e;
    e = '0;
    return e;
  endfunction

  task automatic push(input exp_t e, input string t);
    q.push_back(e);
    qt.push_back(t);
  endtask

  task automatic gen(input logic [7:0] p);
    logic [7:0] b0, b1, b2;
    logic [2:0] ra, rb;
    logic [3:0] fc;
    string ft, xt;
    exp_t e;
    b0 = mem[p];
    b1 = mem[8'(p + 8'd1)];
    b2 = mem[8'(p + 8'd2)];
    ra = b1[6:4];
    rb = b1[2:0];
    ft = (p >= 8'hFE) ? "R12" : "R2";
    xt = (b0[7:6] != 2'b00) ? "R3" : ((b1[7] | b1[3]) ? "R4" : "");
    push(idle(), "R5");
    e = idle(); e.ca = 1'b1; e.addr = p;                push(e, ft);
    push(idle(), ft);
    e = idle(); e.ca = 1'b1; e.addr = 8'(p + 8'd1);     push(e, ft);
    push(idle(), ft);
    e = idle(); e.ca = 1'b1; e.addr = 8'(p + 8'd2);     push(e, ft);
    fc = 4'hF;
    case (b0[5:0])
      6'h04: fc = 4'b0001;
      6'h06: fc = 4'b0110;
      6'h08: fc = 4'b0010;
      6'h0E: fc = 4'b0101;
      6'h16: fc = 4'b1100;
      6'h19: fc = 4'b1000;
      6'h1C: fc = 4'b1010;
      default: ;
    endcase
    if (fc != 4'hF) begin
      e = idle(); e.cw = {ra, rb, ra, fc, 3'b000};
      push(e, xt != "" ? xt : "R6");
    end else begin
      case (b0[5:0])
        6'h00: begin
          push(idle(), "R8");
          e = idle(); e.cw = {6'b0, ra, 7'b0}; e.cd = 1'b1; e.din = in_port;
          push(e, xt != "" ? xt : "R8");
        end
        6'h01: begin
          e = idle(); e.cw = {3'b000, rb, ra, 4'b0010, 3'b000}; e.adis = 1'b1;
          push(e, xt != "" ? xt : "R7");
        end
        6'h02: begin
          push(idle(), "R9");
          e = idle(); e.ca = 1'b1; e.addr = b2;          push(e, "R9");
          push(idle(), "R9");
          e = idle(); e.cw = {6'b0, ra, 7'b0}; e.cd = 1'b1; e.din = mem[b2];
          push(e, xt != "" ? xt : "R9");
        end
        6'h03: begin
          e = idle(); e.cw = {3'b000, rb, 3'b000, 4'b0010, 3'b000}; e.adis = 1'b1;
          push(e, "R10");
          e = idle(); e.we = 1'b1; e.ca = 1'b1; e.addr = b2;
          e.cwd = (rb != 3'd0); e.wd = regs[rb];
          push(e, xt != "" ? xt : "R10");
        end
        default: push(idle(), "R11");
      endcase
    end
  endtask

  task automatic final_chk();
    ck("R6", "reg1 after add/and/inc", regs[1], 8'h02);
    ck("R6", "reg3 after or/dec", regs[3], 8'h7A);
    ck("R7", "reg4 after move/sub/xor", regs[4], 8'h21);
    ck("R9", "reg5 loaded from stored cell", regs[5], 8'h21);
    ck("R10", "mem[E0]", mem[8'hE0], 8'h21);
    ck("R10", "mem[E1] via reserved-bit opcode", mem[8'hE1], 8'h7A);
  endtask

  task automatic step_chk();
    exp_t e;
    string t;
    if (q.size() == 0) begin
      if (ninstr == 15) final_chk();
      gen(pc_m);
      pc_m = 8'(pc_m + 8'd3);
      ninstr++;
    end
    e = q.pop_front();
    t = qt.pop_front();
    ck(t, "cw", cw, e.cw);
    ck(t, "a_bus_dis", a_bus_dis, e.adis);
    ck(t, "mem_we", mem_we, e.we);
    if (e.ca)  ck(t, "mem_addr", mem_addr, e.addr);
    if (e.cd)  ck(t, "dp_in", dp_in, e.din);
    if (e.cwd) ck(t, "mem_wdata", mem_wdata, e.wd);
  endtask

  task automatic put(input logic [7:0] p, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    mem[p] = a;
    mem[8'(p + 8'd1)] = b;
    mem[8'(p + 8'd2)] = c;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h3F;
    for (int i = 0; i < 8; i++) regs[i] = 8'h00;
    in_port = 8'h5A;
    put(8'd0,  8'h00, 8'h10, 8'h00); // R8 input to reg1
    put(8'd3,  8'h02, 8'h30, 8'hF0); // R9 reg3 <- mem[F0]
    put(8'd6,  8'h08, 8'h13, 8'h00); // add 1,3
    put(8'd9,  8'h01, 8'h41, 8'h00); // R7 move reg4 <- reg1
    put(8'd12, 8'h0E, 8'h43, 8'h00); // sub 4,3
    put(8'd15, 8'h16, 8'h13, 8'h00); // and 1,3
    put(8'd18, 8'h19, 8'h34, 8'h00); // or 3,4
    put(8'd21, 8'h1C, 8'h43, 8'h00); // xor 4,3
    put(8'd24, 8'h04, 8'h98, 8'h00); // R4 inc 1 with reserved bits set
    put(8'd27, 8'h06, 8'h30, 8'h00); // dec 3
    put(8'd30, 8'h14, 8'h11, 8'h00); // R11 unused opcode
    put(8'd33, 8'h2A, 8'h22, 8'h00); // R11 unimplemented opcode
    put(8'd36, 8'h03, 8'h04, 8'hE0); // R10 store reg4
    put(8'd39, 8'h43, 8'h83, 8'hE1); // R3 store reg3, reserved opcode bits
    put(8'd42, 8'h02, 8'h50, 8'hE0); // R9 load back
    mem[8'hF0] = 8'h33;

    repeat (3) @(negedge clk);
    ck("R1", "cw in reset", cw, 0);
    ck("R1", "mem_we in reset", mem_we, 0);
    ck("R1", "a_bus_dis in reset", a_bus_dis, 0);
    ck("R1", "mem_addr in reset", mem_addr, 0);
    rst_n = 1'b1;
    #1 step_chk();
    for (int c = 0; c < 900; c++) begin
      @(negedge clk);
      #1 step_chk();
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule